// File: doc/BRIEF.md
# Two-Wire Debug Frame Master

This block is the master side of a two-wire debug and programming link to a small 8051-class target. One wire is a clock that the block always drives while the link is enabled. The other is a bidirectional data wire, driven through an output enable and otherwise read. A host places an operation code and a byte on the request port. The block then runs one complete frame: select a target register (write address), read the address/status register, write one data byte, read one data byte, or reset the target by holding the clock low for a long time.

All wire timing is counted in microsecond ticks taken from a prescaler (`TICKS_PER_US` system cycles per microsecond). Each bit of a frame occupies one "slot". A slot starts with one setup cycle in which the clock is high and the data wire already carries its new value. The clock then goes low for a short time and high again. The clock-low width matters: a long low resets the target, so ordinary strobes stay short. Data frames include a target-paced WAIT field. The block polls it a bounded number of times, and if the target never answers it ends the frame with a timeout flag.

Top module: `tw_frame_master`

## Requirements
- R1: `wire_ck_oe` equals `access_en` delayed by one clock. While it is low, `wire_d_oe` is low too. Whenever the clock output is enabled and no slot is in its low phase, `wire_ck_o` is high, including the cycle in which the enable rises.
- R2: An ordinary slot is one setup cycle with the clock high, then `STB_LOW_US*TICKS_PER_US` cycles with the clock low, then `STB_HIGH_US*TICKS_PER_US` cycles with the clock high. The slots of a frame follow one another with no gap.
- R3: Op code 4 (reset) is a single slot with `RST_LOW_US*TICKS_PER_US` low cycles and `RST_TAIL_US*TICKS_PER_US` high cycles. The data wire stays released throughout.
- R4: Every other frame opens with one slot with the data wire released and closes with one slot with the data wire released.
- R5: After the opening slot, two driven slots carry the 2-bit frame code, bit 0 first. The code is 00 for read data (op 0), 01 for write data (op 1), 10 for read address (op 2) and 11 for write address (op 3).
- R6: Data frames (ops 0 and 1) send two more driven slots, both 0 (length of one byte), right after the code.
- R7: Write frames drive the request byte, bit 0 first, one bit per slot. The data wire never changes while the clock is low.
- R8: Read frames release the data wire for eight slots. `wire_d_i` is sampled at the last cycle of each slot, and the first sample becomes bit 0. `rd_byte` holds the assembled byte from the done cycle onward.
- R9: In write-data frames the byte comes before WAIT. In read-data frames WAIT comes before the byte. Address frames have no WAIT.
- R10: WAIT slots release the data wire and sample once each. The first high sample ends WAIT. After `WAIT_TRIES` low samples, the frame ends without its closing slot and reports a timeout.
- R11: `done` is high for exactly one cycle, the cycle after the last slot. `timeout_err` is high only in that cycle, and only for a timed-out WAIT.
- R12: A request is taken only when the block is idle, `wire_ck_oe` is high and the op code is 0 to 4. Any other request has no effect.
- R13: `busy` is high from the cycle after a request is taken through the done cycle, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| access_en | input | 1 | Enables driving of the two wires |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Operation: 0 read data, 1 write data, 2 read address, 3 write address, 4 reset |
| req_byte | input | 8 | Address or data byte to send |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| timeout_err | output | 1 | WAIT timed out; valid with done |
| rd_byte | output | 8 | Byte read from the target |
| wire_ck_o | output | 1 | Clock wire value |
| wire_ck_oe | output | 1 | Clock wire output enable |
| wire_d_o | output | 1 | Data wire value when driven |
| wire_d_oe | output | 1 | Data wire output enable |
| wire_d_i | input | 1 | Data wire as seen at the pin |

## Verification
The embedded properties check timing and handshake invariants on every clock:
- every clock-low phase has exactly its programmed width;
- the data wire is frozen while the clock is low;
- the clock is high when its enable rises;
- `done` lasts one cycle and `timeout_err` only appears with it;
- the WAIT retry counter stays in bounds;
- `busy` only rises after a legal request with the link enabled.

The order of fields, the frame codes, the length bits, the assembled read bytes and the three WAIT outcomes (immediate, late, never) are shown only by the bench. Its behavioural model predicts every cycle of every frame and compares the wires against it. The bench scenarios also show that requests arriving while busy, while the link is disabled, or with an unused op code leave the wires untouched.

// File: rtl/tw_pkg.sv
package tw_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [2:0] {
        OP_RD_DATA = 3'd0,
        OP_WR_DATA = 3'd1,
        OP_RD_ADDR = 3'd2,
        OP_WR_ADDR = 3'd3,
        OP_RESET   = 3'd4
    } tw_op_e;

    typedef enum logic [3:0] {
        FLD_IDLE,
        FLD_OPEN,
        FLD_CODE,
        FLD_LEN,
        FLD_TX,
        FLD_RX,
        FLD_WAIT,
        FLD_CLOSE,
        FLD_RST,
        FLD_DONE
    } tw_fld_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LOW,
        PH_HIGH
    } tw_ph_e;

    function automatic logic op_legal(input logic [2:0] op);
        return op <= OP_RESET;
    endfunction

    function automatic logic op_is_data(input logic [2:0] op);
        return (op == OP_RD_DATA) || (op == OP_WR_DATA);
    endfunction

    function automatic logic op_reads_byte(input logic [2:0] op);
        return (op == OP_RD_DATA) || (op == OP_RD_ADDR);
    endfunction

endpackage

// File: rtl/tw_tick.sv
module tw_tick #(
    parameter int unsigned TICKS_PER_US = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic tick
);
    localparam int unsigned CW = (TICKS_PER_US > 1) ? $clog2(TICKS_PER_US) : 1;

    logic [CW-1:0] cnt;

    assign tick = (cnt == CW'(TICKS_PER_US - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/tw_pulse.sv
module tw_pulse
    import tw_pkg::*;
#(
    parameter int unsigned TICKS_PER_US = 100,
    parameter int unsigned USW          = 5
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [USW-1:0] low_us,
    input  logic [USW-1:0] high_us,
    output logic           ck_low,
    output logic           slot_end
);
    tw_ph_e         ph;
    logic [USW-1:0] us_cnt;
    logic [USW-1:0] lo_q;
    logic [USW-1:0] hi_q;
    logic           tick;
    logic           phase_done;

    tw_tick #(.TICKS_PER_US(TICKS_PER_US)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .clr  (start),
        .tick (tick)
    );

    assign phase_done = tick &&
        (us_cnt == (((ph == PH_LOW) ? lo_q : hi_q) - USW'(1)));
    assign ck_low   = (ph == PH_LOW);
    assign slot_end = (ph == PH_HIGH) && phase_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph     <= PH_IDLE;
            us_cnt <= '0;
            lo_q   <= '0;
            hi_q   <= '0;
        end else if (start) begin
            ph     <= PH_LOW;
            us_cnt <= '0;
            lo_q   <= low_us;
            hi_q   <= high_us;
        end else if ((ph != PH_IDLE) && tick) begin
            if (phase_done) begin
                us_cnt <= '0;
                ph     <= (ph == PH_LOW) ? PH_HIGH : PH_IDLE;
            end else begin
                us_cnt <= us_cnt + USW'(1);
            end
        end
    end

    // Independent cycle counter of the clock-low phase, for the width check.
    logic [15:0] low_cycles;
    always_ff @(posedge clk) begin
        if (rst || (ph != PH_LOW)) begin
            low_cycles <= '0;
        end else begin
            low_cycles <= low_cycles + 16'd1;
        end
    end

    // Low width of strobes (and of the reset pulse, R3) is exact.
    assert_low_width_R2: assert property (@(posedge clk) disable iff (rst)
        (ck_low && !start && tick && (us_cnt == lo_q - USW'(1)))
        |-> ((32'(low_cycles) + 32'd1) == (32'(lo_q) * TICKS_PER_US)));

    assert_start_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
        start |-> (ph == PH_IDLE));
endmodule

// File: rtl/tw_seq.sv
module tw_seq
    import tw_pkg::*;
#(
    parameter int unsigned WAIT_TRIES  = 20,
    parameter int unsigned STB_LOW_US  = 1,
    parameter int unsigned STB_HIGH_US = 1,
    parameter int unsigned RST_LOW_US  = 25,
    parameter int unsigned RST_TAIL_US = 1,
    parameter int unsigned USW         = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [2:0]        op_in,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              slot_end,
    input  logic              sdi,
    output logic              start,
    output logic [USW-1:0]    lo_us,
    output logic [USW-1:0]    hi_us,
    output logic              drv_oe,
    output logic              drv_val,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [BYTE_W-1:0] rd_byte
);
    localparam int unsigned TW = $clog2(WAIT_TRIES + 1);

    tw_fld_e           fld;
    tw_fld_e           nxt_fld;
    logic [2:0]        op_q;
    logic [BYTE_W-1:0] wr_q;
    logic [BYTE_W-1:0] rd_q;
    logic [2:0]        idx;
    logic [2:0]        nxt_idx;
    logic [TW-1:0]     tries;
    logic              start_q;
    logic              err_q;
    logic              nxt_err;

    always_comb begin
        nxt_fld = fld;
        nxt_idx = idx + 3'd1;
        nxt_err = 1'b0;
        case (fld)
            FLD_OPEN: begin
                nxt_fld = FLD_CODE;
                nxt_idx = 3'd0;
            end
            FLD_CODE: begin
                if (idx == 3'd1) begin
                    nxt_idx = 3'd0;
                    if (op_is_data(op_q))       nxt_fld = FLD_LEN;
                    else if (op_q == OP_WR_ADDR) nxt_fld = FLD_TX;
                    else                         nxt_fld = FLD_RX;
                end
            end
            FLD_LEN: begin
                if (idx == 3'd1) begin
                    nxt_idx = 3'd0;
                    nxt_fld = (op_q == OP_WR_DATA) ? FLD_TX : FLD_WAIT;
                end
            end
            FLD_TX: begin
                if (idx == 3'd7) begin
                    nxt_idx = 3'd0;
                    nxt_fld = (op_q == OP_WR_DATA) ? FLD_WAIT : FLD_CLOSE;
                end
            end
            FLD_RX: begin
                if (idx == 3'd7) begin
                    nxt_idx = 3'd0;
                    nxt_fld = FLD_CLOSE;
                end
            end
            FLD_WAIT: begin
                nxt_idx = idx;
                if (sdi) begin
                    nxt_fld = (op_q == OP_RD_DATA) ? FLD_RX : FLD_CLOSE;
                end else if (tries == TW'(WAIT_TRIES - 1)) begin
                    nxt_fld = FLD_DONE;
                    nxt_err = 1'b1;
                end
            end
            FLD_CLOSE, FLD_RST: nxt_fld = FLD_DONE;
            default: nxt_fld = fld;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fld     <= FLD_IDLE;
            op_q    <= '0;
            wr_q    <= '0;
            rd_q    <= '0;
            idx     <= '0;
            tries   <= '0;
            start_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            start_q <= 1'b0;
            err_q   <= 1'b0;
            case (fld)
                FLD_IDLE: begin
                    if (accept) begin
                        op_q    <= op_in;
                        wr_q    <= byte_in;
                        idx     <= '0;
                        tries   <= '0;
                        fld     <= (op_in == OP_RESET) ? FLD_RST : FLD_OPEN;
                        start_q <= 1'b1;
                    end
                end
                FLD_DONE: fld <= FLD_IDLE;
                default: begin
                    if (slot_end) begin
                        fld     <= nxt_fld;
                        idx     <= nxt_idx;
                        start_q <= (nxt_fld != FLD_DONE);
                        err_q   <= nxt_err;
                        if (fld == FLD_RX)              rd_q  <= {sdi, rd_q[BYTE_W-1:1]};
                        if ((fld == FLD_WAIT) && !sdi)  tries <= tries + TW'(1);
                    end
                end
            endcase
        end
    end

    assign start   = start_q;
    assign lo_us   = (fld == FLD_RST) ? USW'(RST_LOW_US)  : USW'(STB_LOW_US);
    assign hi_us   = (fld == FLD_RST) ? USW'(RST_TAIL_US) : USW'(STB_HIGH_US);
    assign drv_oe  = (fld == FLD_CODE) || (fld == FLD_LEN) || (fld == FLD_TX);
    assign drv_val = (fld == FLD_CODE) ? op_q[idx[0]] :
                     (fld == FLD_TX)   ? wr_q[idx]    : 1'b0;
    assign busy    = (fld != FLD_IDLE);
    assign done    = (fld == FLD_DONE);
    assign err     = err_q;
    assign rd_byte = rd_q;

    assert_err_with_done_R11: assert property (@(posedge clk) disable iff (rst)
        err |-> done);

    assert_done_single_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_wait_bound_R10: assert property (@(posedge clk) disable iff (rst)
        (fld == FLD_WAIT) |-> (tries < TW'(WAIT_TRIES)));
endmodule

// File: rtl/tw_frame_master.sv
module tw_frame_master
    import tw_pkg::*;
#(
    parameter int unsigned TICKS_PER_US = 100,
    parameter int unsigned STB_LOW_US   = 1,
    parameter int unsigned STB_HIGH_US  = 1,
    parameter int unsigned RST_LOW_US   = 25,
    parameter int unsigned RST_TAIL_US  = 1,
    parameter int unsigned WAIT_TRIES   = 20
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       access_en,
    input  logic       req_valid,
    input  logic [2:0] req_op,
    input  logic [7:0] req_byte,
    output logic       busy,
    output logic       done,
    output logic       timeout_err,
    output logic [7:0] rd_byte,
    output logic       wire_ck_o,
    output logic       wire_ck_oe,
    output logic       wire_d_o,
    output logic       wire_d_oe,
    input  logic       wire_d_i
);
    localparam int unsigned MAX_A  = (RST_LOW_US > STB_LOW_US) ? RST_LOW_US : STB_LOW_US;
    localparam int unsigned MAX_B  = (RST_TAIL_US > STB_HIGH_US) ? RST_TAIL_US : STB_HIGH_US;
    localparam int unsigned MAX_US = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int unsigned USW    = $clog2(MAX_US + 1);

    logic           ck_oe_q;
    logic           accept;
    logic           start;
    logic [USW-1:0] lo_us;
    logic [USW-1:0] hi_us;
    logic           ck_low;
    logic           slot_end;
    logic           drv_oe;
    logic           drv_val;
    logic           seq_busy;

    always_ff @(posedge clk) begin
        if (rst) ck_oe_q <= 1'b0;
        else     ck_oe_q <= access_en;
    end

    assign accept = req_valid && !seq_busy && ck_oe_q && op_legal(req_op);

    tw_pulse #(.TICKS_PER_US(TICKS_PER_US), .USW(USW)) u_pulse (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .low_us   (lo_us),
        .high_us  (hi_us),
        .ck_low   (ck_low),
        .slot_end (slot_end)
    );

    tw_seq #(
        .WAIT_TRIES  (WAIT_TRIES),
        .STB_LOW_US  (STB_LOW_US),
        .STB_HIGH_US (STB_HIGH_US),
        .RST_LOW_US  (RST_LOW_US),
        .RST_TAIL_US (RST_TAIL_US),
        .USW         (USW)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .op_in    (req_op),
        .byte_in  (req_byte),
        .slot_end (slot_end),
        .sdi      (wire_d_i),
        .start    (start),
        .lo_us    (lo_us),
        .hi_us    (hi_us),
        .drv_oe   (drv_oe),
        .drv_val  (drv_val),
        .busy     (seq_busy),
        .done     (done),
        .err      (timeout_err),
        .rd_byte  (rd_byte)
    );

    assign busy       = seq_busy;
    assign wire_ck_o  = !ck_low;
    assign wire_ck_oe = ck_oe_q;
    assign wire_d_oe  = drv_oe && ck_oe_q;
    assign wire_d_o   = drv_val && wire_d_oe;

    assert_clk_high_on_enable_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(wire_ck_oe) |-> (wire_ck_o && !wire_d_oe));

    assert_data_still_low_R7: assert property (@(posedge clk) disable iff (rst)
        (!wire_ck_o && !$past(wire_ck_o)) |-> ($stable(wire_d_o) && $stable(wire_d_oe)));

    assert_take_legal_only_R12: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(req_valid) && $past(wire_ck_oe) && ($past(req_op) <= 3'd4)));
endmodule

// File: tb/tw_frame_master_tb_top.sv
module tw_frame_master_tb_top;
    localparam int TPU = 4;
    localparam int SL  = 1;
    localparam int SH  = 1;
    localparam int RL  = 25;
    localparam int RT  = 1;
    localparam int WT  = 20;

    logic       clk = 1'b0;
    logic       rst;
    logic       access_en;
    logic       req_valid;
    logic [2:0] req_op;
    logic [7:0] req_byte;
    logic       busy, done, timeout_err;
    logic [7:0] rd_byte;
    logic       wire_ck_o, wire_ck_oe, wire_d_o, wire_d_oe;
    logic       wire_d_i;

    always #5 clk = ~clk;

    tw_frame_master #(
        .TICKS_PER_US (TPU),
        .STB_LOW_US   (SL),
        .STB_HIGH_US  (SH),
        .RST_LOW_US   (RL),
        .RST_TAIL_US  (RT),
        .WAIT_TRIES   (WT)
    ) dut_i (
        .clk         (clk),
        .rst         (rst),
        .access_en   (access_en),
        .req_valid   (req_valid),
        .req_op      (req_op),
        .req_byte    (req_byte),
        .busy        (busy),
        .done        (done),
        .timeout_err (timeout_err),
        .rd_byte     (rd_byte),
        .wire_ck_o   (wire_ck_o),
        .wire_ck_oe  (wire_ck_oe),
        .wire_d_o    (wire_d_o),
        .wire_d_oe   (wire_d_oe),
        .wire_d_i    (wire_d_i)
    );

    typedef struct {
        bit       ck;
        bit       oe;
        bit       dv;
        bit       di;
        bit       dn;
        bit       er;
        bit       bz;
        bit       crd;
        bit [7:0] rd;
        int       req;
    } cyc_t;

    cyc_t q[$];
    int   checks   = 0;
    int   fails    = 0;
    bit   checking = 1'b0;

    function automatic cyc_t idle_cyc();
        cyc_t e;
        e.ck = 1; e.oe = 0; e.dv = 0; e.di = 1; e.dn = 0; e.er = 0;
        e.bz = 0; e.crd = 0; e.rd = 0; e.req = 12; // R12: idle, nothing taken
        return e;
    endfunction

    // One slot: setup cycle, low phase, high phase (R2 / R3).
    function automatic void push_slot(int lo, int hi, bit oe, bit dv, bit di, int req);
        cyc_t e;
        e.oe = oe; e.dv = dv; e.di = di; e.dn = 0; e.er = 0;
        e.bz = 1; e.crd = 0; e.rd = 0; e.req = req;
        e.ck = 1; q.push_back(e);
        e.ck = 0; for (int i = 0; i < lo * TPU; i++) q.push_back(e);
        e.ck = 1; for (int i = 0; i < hi * TPU; i++) q.push_back(e);
    endfunction

    function automatic void push_done(bit er, bit crd, bit [7:0] rd, int req);
        cyc_t e;
        e.ck = 1; e.oe = 0; e.dv = 0; e.di = 1; e.dn = 1; e.er = er;
        e.bz = 1; e.crd = crd; e.rd = rd; e.req = req; // R11, R13
        q.push_back(e);
    endfunction

    // Behavioural frame model built from the requirements.
    function automatic void plan_frame(bit [2:0] op, bit [7:0] wb, bit [7:0] tb, int lows);
        bit is_data = (op == 3'd0) || (op == 3'd1);
        if (op == 3'd4) begin
            push_slot(RL, RT, 0, 0, 1, 3);          // R3
            push_done(0, 0, 8'h00, 11);
            return;
        end
        push_slot(SL, SH, 0, 0, 1, 4);              // R4 opening slot
        push_slot(SL, SH, 1, op[0], 1, 5);          // R5 code bit 0
        push_slot(SL, SH, 1, op[1], 1, 5);          // R5 code bit 1
        if (is_data) begin
            push_slot(SL, SH, 1, 0, 1, 6);          // R6 length
            push_slot(SL, SH, 1, 0, 1, 6);
        end
        if (op == 3'd1 || op == 3'd3) begin
            for (int i = 0; i < 8; i++) push_slot(SL, SH, 1, wb[i], 1, 7); // R7
        end
        if (is_data) begin
            for (int k = 0; k < lows && k < WT; k++) push_slot(SL, SH, 0, 0, 0, 10); // R10
            if (lows >= WT) begin
                push_done(1, 0, 8'h00, 10);         // R10 timeout, no closing slot
                return;
            end
            push_slot(SL, SH, 0, 0, 1, 9);          // R9 WAIT answered
        end
        if (op == 3'd0 || op == 3'd2) begin
            for (int i = 0; i < 8; i++) push_slot(SL, SH, 0, 0, tb[i], 8); // R8
        end
        push_slot(SL, SH, 0, 0, 1, 4);              // R4 closing slot
        push_done(0, (op == 3'd0 || op == 3'd2), tb, 8);
    endfunction

    task automatic finish_up();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    task automatic check_bit(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Runs a frame. poke>0 injects a stray request that many cycles in (R12).
    task automatic run_frame(bit [2:0] op, bit [7:0] wb, bit [7:0] tb, int lows, int poke);
        @(negedge clk);
        req_op    = op;
        req_byte  = wb;
        req_valid = 1'b1;
        plan_frame(op, wb, tb, lows);
        @(negedge clk);
        req_valid = 1'b0;
        if (poke > 0) begin
            repeat (poke) @(negedge clk);
            req_op    = 3'd3;
            req_byte  = 8'hFF;
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Per-cycle comparison against the model, sampled 2 ns after each edge.
    initial begin
        cyc_t e;
        bit   a;
        wait (checking);
        forever begin
            @(posedge clk);
            a = access_en;
            #2;
            if (q.size() > 0) e = q.pop_front();
            else              e = idle_cyc();
            wire_d_i = e.di;
            checks++;
            if (wire_ck_o !== e.ck || wire_ck_oe !== a || wire_d_oe !== (e.oe & a) ||
                wire_d_o !== (e.dv & e.oe & a) || done !== e.dn ||
                timeout_err !== e.er || busy !== e.bz) begin
                fails++;
                $display("FAIL R%0d t=%0t actual ck=%b ckoe=%b doe=%b do=%b done=%b err=%b busy=%b expected ck=%b ckoe=%b doe=%b do=%b done=%b err=%b busy=%b",
                         e.req, $time, wire_ck_o, wire_ck_oe, wire_d_oe, wire_d_o, done,
                         timeout_err, busy, e.ck, a, e.oe & a, e.dv & e.oe & a, e.dn, e.er, e.bz);
            end
            if (e.crd) begin
                checks++;
                if (rd_byte !== e.rd) begin
                    fails++;
                    $display("FAIL R8 read byte actual=%h expected=%h", rd_byte, e.rd);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R13 watchdog actual=running expected=finished");
        finish_up();
    end

    initial begin
        rst       = 1'b1;
        access_en = 1'b0;
        req_valid = 1'b0;
        req_op    = 3'd0;
        req_byte  = 8'h00;
        wire_d_i  = 1'b1;
        repeat (3) @(negedge clk);
        rst      = 1'b0;
        checking = 1'b1;
        @(negedge clk);
        // Reset state: R1 lines released, R13 idle, R11 no flags, R8 byte cleared.
        check_bit("R1 reset ck_oe", wire_ck_oe, 1'b0);
        check_bit("R1 reset d_oe", wire_d_oe, 1'b0);
        check_bit("R13 reset busy", busy, 1'b0);
        check_bit("R11 reset done", done, 1'b0);
        checks++;
        if (rd_byte !== 8'h00) begin
            fails++;
            $display("FAIL R8 reset rd_byte actual=%h expected=00", rd_byte);
        end
        repeat (2) @(negedge clk);

        // R12: request with the link disabled is ignored.
        req_op = 3'd3; req_byte = 8'h55; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (4) @(negedge clk);

        // R1: enable the link, clock enable follows one cycle later.
        access_en = 1'b1;
        repeat (3) @(negedge clk);

        run_frame(3'd3, 8'hB4, 8'h00, 0, 30);   // R5 R7 write address, stray request R12
        run_frame(3'd2, 8'h00, 8'h3C, 0, 0);    // R8 read address
        run_frame(3'd1, 8'h5A, 8'h00, 3, 0);    // R6 R9 R10 write data, late answer
        run_frame(3'd0, 8'h00, 8'hA7, 0, 0);    // R9 read data, immediate answer
        run_frame(3'd0, 8'h00, 8'h81, 5, 0);    // R8 R10 read data, delayed answer
        run_frame(3'd1, 8'hC3, 8'h00, WT, 0);   // R10 R11 timeout
        run_frame(3'd4, 8'h00, 8'h00, 0, 40);   // R3 reset frame with stray request

        // R12: unused op code has no effect.
        @(negedge clk);
        req_op = 3'd6; req_byte = 8'h12; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (4) @(negedge clk);

        // R1: disable the link, both lines released.
        access_en = 1'b0;
        repeat (3) @(negedge clk);
        check_bit("R1 off ck_oe", wire_ck_oe, 1'b0);
        check_bit("R1 off d_oe", wire_d_oe, 1'b0);
        repeat (2) @(negedge clk);
        finish_up();
    end
endmodule